// File: doc/BRIEF.md
# Signed/Unsigned Baugh-Wooley Array Multiplier

This block multiplies two `OP_W`-bit operands (8 bits by default) and returns a product twice as wide. A single input, `signed_mode`, selects how the operands are read. They are either two's complement or plain unsigned values. One adder array serves both readings.

Each bit of operand `mul_a` gates a copy of `mul_b` to form a shifted partial-product row. In signed mode, selected row bits are inverted and two constant ones are injected. This lets every row be added as an unsigned word, so no row needs sign extension and no row is subtracted. The rows are summed by either a ripple-carry chain or a carry-save chain. The chain is chosen by a parameter, and either one ends in a single ripple adder. The result is taken modulo 2^(2*OP_W).

Operands and mode are sampled on a clock edge where `in_valid` is high. The product is registered on that same edge, and `out_valid` is high for the following cycle. The registered product holds between strobes.

Top module: `bw_mult_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `product` becomes 0 and `out_valid` becomes 0 after that edge (synchronous, active-high reset).
- R2: With `signed_mode` = 0, a strobe of operands x and y yields `product` = x*y as unsigned integers, modulo 2^16.
- R3: With `signed_mode` = 1, a strobe yields the two's complement product of x and y in 16 bits.
- R4: In signed mode, 0x80 times 0x80 (-128 * -128) yields 0x4000 (+16384) with no wraparound.
- R5: In signed mode, 0x80 times 0x7F (-128 * 127) yields 0xC080 (-16256), in either operand order.
- R6: 0xFF times 0xFF yields 0x0001 in signed mode (-1 * -1) and 0xFE01 in unsigned mode (255 * 255).
- R7: A zero operand on either side yields a product of 0 in both modes.
- R8: `out_valid` is high in exactly the cycles that follow a rising edge at which `in_valid` was high. Back-to-back strobes give one result per cycle.
- R9: When `in_valid` is low at an edge, changes to `mul_a`, `mul_b` and `signed_mode` have no effect: `product` keeps its value.
- R10: The mode is sampled together with the operands, so the same operand bits give different results when strobed in different modes on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: sample operands and mode on this edge |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| mul_a | input | OP_W | Multiplier operand, one partial-product row per bit |
| mul_b | input | OP_W | Multiplicand operand |
| out_valid | output | 1 | High for one cycle per sampled strobe |
| product | output | 2*OP_W | Registered product, held between strobes |

## Verification
Every result is due one cycle after its strobe. The strobe is sampled at rising edge k, and `product` and `out_valid` carry that result between edge k and edge k+1. The bench drives inputs on falling edges. It then reads outputs at the next falling edge, half a cycle after the capturing edge and before the next inputs are applied. In streamed sweeps, each check is therefore paired with the operands driven one cycle earlier. In hold tests, `product` is compared at every falling edge across the cycles without a strobe.

// File: rtl/bw_mult_pkg.sv
package bw_mult_pkg;

   // Summation chain variants
   localparam int ADD_RIPPLE = 0;
   localparam int ADD_CSA    = 1;

   // True when partial-product bit (row, col) is inverted in signed mode:
   // the sign column of every row but the last, and every non-sign column
   // of the last row.
   function automatic logic bw_flip_bit(input int row, input int col, input int opw);
      return ((row == opw - 1) != (col == opw - 1));
   endfunction

   // Column positions of the two injected ones in signed mode
   function automatic int bw_const_lo(input int opw);
      return opw;
   endfunction

   function automatic int bw_const_hi(input int opw);
      return 2 * opw - 1;
   endfunction

endpackage

// File: rtl/bw_rca.sv
module bw_rca #(
   parameter int W = 16
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic [W-1:0] s
);
   logic [W-1:0] cy;

   assign cy[0] = 1'b0;

   for (genvar k = 0; k < W; k++) begin : g_bit
      assign s[k] = x[k] ^ y[k] ^ cy[k];
      if (k < W - 1) begin : g_carry
         assign cy[k+1] = (x[k] & y[k]) | (x[k] & cy[k]) | (y[k] & cy[k]);
      end
   end

endmodule

// File: rtl/bw_csa.sv
module bw_csa #(
   parameter int W = 16
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic [W-1:0] z,
   output logic [W-1:0] s,
   output logic [W-1:0] c
);
   assign c[0] = 1'b0;

   for (genvar k = 0; k < W; k++) begin : g_bit
      assign s[k] = x[k] ^ y[k] ^ z[k];
      if (k < W - 1) begin : g_carry
         // carry weighted one column up; the carry out of the top column is dropped
         assign c[k+1] = (x[k] & y[k]) | (x[k] & z[k]) | (y[k] & z[k]);
      end
   end

endmodule

// File: rtl/bw_pp_rows.sv
module bw_pp_rows
   import bw_mult_pkg::*;
#(
   parameter int OP_W = 8,
   localparam int PW   = 2 * OP_W,
   localparam int ROWS = OP_W + 1
) (
   input  logic [OP_W-1:0]          a,
   input  logic [OP_W-1:0]          b,
   input  logic                     signed_mode,
   output logic [ROWS-1:0][PW-1:0]  rows
);
   localparam int CLO = bw_const_lo(OP_W);
   localparam int CHI = bw_const_hi(OP_W);

   always_comb begin
      rows = '0;
      for (int i = 0; i < OP_W; i++) begin
         for (int j = 0; j < OP_W; j++) begin
            rows[i][i+j] = (a[i] & b[j]) ^ (signed_mode & bw_flip_bit(i, j, OP_W));
         end
      end
      // correction row: two fixed ones, present only for signed operands
      rows[OP_W][CLO] = signed_mode;
      rows[OP_W][CHI] = signed_mode;
   end

endmodule

// File: rtl/bw_sum_array.sv
module bw_sum_array
   import bw_mult_pkg::*;
#(
   parameter int ROWS  = 9,
   parameter int W     = 16,
   parameter int STYLE = ADD_RIPPLE
) (
   input  logic [ROWS-1:0][W-1:0] rows,
   output logic [W-1:0]           total
);

   if (STYLE == ADD_RIPPLE) begin : g_ripple
      logic [ROWS-1:0][W-1:0] acc;
      assign acc[0] = rows[0];
      for (genvar r = 1; r < ROWS; r++) begin : g_stage
         bw_rca #(.W(W)) u_add (
            .x (acc[r-1]),
            .y (rows[r]),
            .s (acc[r])
         );
      end
      assign total = acc[ROWS-1];
   end else begin : g_csa
      logic [ROWS-1:0][W-1:0] ps;
      logic [ROWS-1:0][W-1:0] pc;
      assign ps[0] = rows[0];
      assign pc[0] = '0;
      for (genvar r = 1; r < ROWS; r++) begin : g_stage
         bw_csa #(.W(W)) u_cmp (
            .x (ps[r-1]),
            .y (pc[r-1]),
            .z (rows[r]),
            .s (ps[r]),
            .c (pc[r])
         );
      end
      bw_rca #(.W(W)) u_final (
         .x (ps[ROWS-1]),
         .y (pc[ROWS-1]),
         .s (total)
      );
   end

endmodule

// File: rtl/bw_out_stage.sv
module bw_out_stage #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic         vld_q,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q     <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= load;
         if (load) begin
            q <= d;
         end
      end
   end

endmodule

// File: rtl/bw_mult_top.sv
module bw_mult_top
   import bw_mult_pkg::*;
#(
   parameter int OP_W        = 8,
   parameter int ADDER_STYLE = ADD_RIPPLE,
   localparam int PW         = 2 * OP_W,
   localparam int ROWS       = OP_W + 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   input  logic            signed_mode,
   input  logic [OP_W-1:0] mul_a,
   input  logic [OP_W-1:0] mul_b,
   output logic            out_valid,
   output logic [PW-1:0]   product
);

   initial begin
      if (OP_W < 2) $fatal(1, "bw_mult_top: OP_W must be at least 2");
      if (ADDER_STYLE != ADD_RIPPLE && ADDER_STYLE != ADD_CSA)
         $fatal(1, "bw_mult_top: unknown ADDER_STYLE");
   end

   logic [ROWS-1:0][PW-1:0] pp_rows;
   logic [PW-1:0]           pp_sum;

   bw_pp_rows #(.OP_W(OP_W)) u_rows (
      .a           (mul_a),
      .b           (mul_b),
      .signed_mode (signed_mode),
      .rows        (pp_rows)
   );

   bw_sum_array #(.ROWS(ROWS), .W(PW), .STYLE(ADDER_STYLE)) u_sum (
      .rows  (pp_rows),
      .total (pp_sum)
   );

   bw_out_stage #(.W(PW)) u_out (
      .clk   (clk),
      .rst   (rst),
      .load  (in_valid),
      .d     (pp_sum),
      .vld_q (out_valid),
      .q     (product)
   );

endmodule

// File: rtl/bw_mult_chk.sv
module bw_mult_chk #(
   parameter int OP_W = 8,
   localparam int PW  = 2 * OP_W
) (
   input logic            clk,
   input logic            rst,
   input logic            in_valid,
   input logic            signed_mode,
   input logic [OP_W-1:0] mul_a,
   input logic [OP_W-1:0] mul_b,
   input logic            out_valid,
   input logic [PW-1:0]   product
);
   logic [PW-1:0] ref_u;
   logic [PW-1:0] ref_s;

   always_comb begin
      ref_u = {{OP_W{1'b0}}, mul_a} * {{OP_W{1'b0}}, mul_b};
      ref_s = {{OP_W{mul_a[OP_W-1]}}, mul_a} * {{OP_W{mul_b[OP_W-1]}}, mul_b};
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (product == '0) && !out_valid); // R1

   AST_UNSIGNED_PRODUCT: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !signed_mode) |=> product == $past(ref_u)); // R2

   AST_SIGNED_PRODUCT: assert property (@(posedge clk) disable iff (rst)
      (in_valid && signed_mode) |=> product == $past(ref_s)); // R3

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R8

   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid); // R8

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(product)); // R9

endmodule

bind bw_mult_top bw_mult_chk #(.OP_W(OP_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .in_valid    (in_valid),
   .signed_mode (signed_mode),
   .mul_a       (mul_a),
   .mul_b       (mul_b),
   .out_valid   (out_valid),
   .product     (product)
);

// File: tb/bw_mult_top_tb_top.sv
module bw_mult_top_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        signed_mode = 1'b0;
   logic [7:0]  mul_a = '0;
   logic [7:0]  mul_b = '0;
   logic        out_valid;
   logic [15:0] product;

   int checks   = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   bw_mult_top dut_i (
      .clk         (clk),
      .rst         (rst),
      .in_valid    (in_valid),
      .signed_mode (signed_mode),
      .mul_a       (mul_a),
      .mul_b       (mul_b),
      .out_valid   (out_valid),
      .product     (product)
   );

   function automatic logic [15:0] ref_mul(logic [7:0] x, logic [7:0] y, logic sm);
      int xi;
      int yi;
      int p;
      xi = sm ? int'($signed(x)) : int'(x);
      yi = sm ? int'($signed(y)) : int'(y);
      p  = xi * yi;
      return p[15:0];
   endfunction

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
      end
   endtask

   // one strobe, result read half a cycle after the capturing edge
   task automatic run_one(string req, logic [7:0] x, logic [7:0] y, logic sm);
      @(negedge clk);
      mul_a = x; mul_b = y; signed_mode = sm; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk({req, " product"}, product, ref_mul(x, y, sm));
      chk("R8 valid after strobe", {15'd0, out_valid}, 16'd1);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 product in reset", product, 16'h0000);
      chk("R1 valid in reset", {15'd0, out_valid}, 16'd0);
      rst = 1'b0;
      @(negedge clk);
      chk("R8 no valid without strobe", {15'd0, out_valid}, 16'd0);
   endtask

   task automatic t_corners();
      run_one("R4", 8'h80, 8'h80, 1'b1);
      chk("R4 literal", product, 16'h4000);
      run_one("R5", 8'h80, 8'h7F, 1'b1);
      chk("R5 literal", product, 16'hC080);
      run_one("R5 swapped", 8'h7F, 8'h80, 1'b1);
      chk("R5 swapped literal", product, 16'hC080);
      run_one("R6 signed", 8'hFF, 8'hFF, 1'b1);
      chk("R6 signed literal", product, 16'h0001);
      run_one("R6 unsigned", 8'hFF, 8'hFF, 1'b0);
      chk("R6 unsigned literal", product, 16'hFE01);
      run_one("R7 signed", 8'h00, 8'hB3, 1'b1);
      chk("R7 signed literal", product, 16'h0000);
      run_one("R7 unsigned", 8'hC8, 8'h00, 1'b0);
      chk("R7 unsigned literal", product, 16'h0000);
      run_one("R3 mixed sign", 8'h05, 8'hFD, 1'b1);
      chk("R3 literal", product, 16'hFFF1);
      run_one("R2 plain", 8'h0B, 8'h0E, 1'b0);
      chk("R2 literal", product, 16'h009A);
   endtask

   task automatic t_hold();
      run_one("R9 setup", 8'h12, 8'h34, 1'b0);
      for (int k = 0; k < 5; k++) begin
         mul_a = 8'(k * 37 + 1); mul_b = 8'(k * 91 + 3); signed_mode = k[0];
         @(negedge clk);
         chk("R9 product held", product, 16'h03A8);
         chk("R8 idle valid low", {15'd0, out_valid}, 16'd0);
      end
   endtask

   task automatic t_mode_switch();
      @(negedge clk);
      mul_a = 8'hF0; mul_b = 8'h03; signed_mode = 1'b1; in_valid = 1'b1;
      @(negedge clk);
      chk("R10 signed first", product, 16'hFFD0);
      signed_mode = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R10 unsigned second", product, 16'h02D0);
      chk("R8 back-to-back valid", {15'd0, out_valid}, 16'd1);
   endtask

   // streamed sweep over every operand pair, one strobe per cycle
   task automatic t_sweep(logic sm);
      logic [15:0] exp_prev;
      exp_prev = '0;
      for (int n = 0; n <= 65536; n++) begin
         @(negedge clk);
         if (n > 0) begin
            chk(sm ? "R3 sweep" : "R2 sweep", product, exp_prev);
            chk("R8 sweep valid", {15'd0, out_valid}, 16'd1);
         end
         if (n < 65536) begin
            mul_a = n[15:8]; mul_b = n[7:0]; signed_mode = sm; in_valid = 1'b1;
            exp_prev = ref_mul(n[15:8], n[7:0], sm);
         end else begin
            in_valid = 1'b0;
         end
      end
   endtask

   task automatic t_reset_mid();
      run_one("R1 setup", 8'h40, 8'h40, 1'b0);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R1 reset clears product", product, 16'h0000);
      chk("R1 reset clears valid", {15'd0, out_valid}, 16'd0);
      rst = 1'b0;
   endtask

   initial begin
      t_reset();
      t_corners();
      t_hold();
      t_mode_switch();
      t_sweep(1'b1);
      t_sweep(1'b0);
      t_reset_mid();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL R8 watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule